// File: doc/BRIEF.md
# Supply supervisor reset generator

This block turns a logic-level supply-good signal and an active-low manual reset request into a stretched processor reset. A threshold comparator outside the block decides whether the supply is good. The block synchronizes both inputs, asserts reset as soon as the synchronized supply reads bad or the manual request is low, and keeps reset asserted for a fixed hold time after both conditions clear. It drives two reset outputs, one active-high and one active-low, which are always complements of each other.

The hold counter reloads in every cycle that a trigger is present. A supply dip that arrives while reset is already active therefore restarts the stretch. A bouncing pushbutton on the manual input yields one clean pulse, so no separate debounce stage is needed. A watchdog may share the manual input. All durations are parameters in clock cycles, so simulation can use scaled-down values.

Top module: `supv_reset_gen`

## Requirements
- R1: While the synchronized supply-good input reads 0, reset is asserted (rst_hi = 1). This includes the time from power-on until the supply first reads good.
- R2: After the last cycle in which a trigger is driven at the inputs, reset stays asserted for HOLD_CYC cycles beyond the 2-cycle synchronizer delay. An input held low during input cycle j asserts reset at samples j+2 through j+2+HOLD_CYC.
- R3: Every reset pulse lasts at least MIN_CYC cycles, however short the trigger. A parameter set with MIN_CYC greater than HOLD_CYC is rejected at elaboration.
- R4: A supply drop that arrives while reset is still being held restarts the full hold time from the end of that drop, so reset stays continuously asserted.
- R5: A low level on man_rst_n asserts reset with the same stretch as a supply drop. A bouncing low/high sequence whose gaps are shorter than the hold time gives one continuous pulse.
- R6: rst_lo_n is always the exact complement of rst_hi.
- R7: A supply drop asserts reset right after the synchronizer, 2 clock edges after the input changes, with no added delay.
- R8: While init_n is low, reset is asserted and the hold counter is loaded with HOLD_CYC. With both inputs good, reset is released HOLD_CYC+2 cycles after init_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| init_n | input | 1 | Active-low power-on initialization |
| supply_ok | input | 1 | Supply-good level from the external comparator (asynchronous) |
| man_rst_n | input | 1 | Active-low manual reset request (asynchronous, may bounce) |
| rst_hi | output | 1 | Active-high reset output |
| rst_lo_n | output | 1 | Active-low reset output |

## Verification
The assertions assume that supply_ok and man_rst_n are plain levels that are sampled only through the synchronizer. They also assume that HOLD_CYC is at least MIN_CYC, so a pulse measured from its start is never shorter than the minimum. The stimulus changes the inputs only at falling clock edges and holds each value for whole cycles. It covers low pulses on each input of every width from 1 to 8 cycles, then a brown-out and a bouncing pushbutton whose gaps stay below the hold time, so the expected assertion window for each sample is the union of j+2 through j+2+HOLD_CYC over all low cycles j.

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
  parameter int HOLD_CYC = 12,
  parameter int MIN_CYC  = 8
) (
  input  logic clk,
  input  logic init_n,
  input  logic supply_ok,
  input  logic man_rst_n,
  output logic rst_hi,
  output logic rst_lo_n
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam int MW = CW + 1;
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

  generate
    if (MIN_CYC > HOLD_CYC) begin : g_bad_cfg
      $error("MIN_CYC must not exceed HOLD_CYC");
    end
  endgenerate

  logic [1:0]    sok_q, mr_q;
  logic [CW-1:0] hold_cnt;
  logic          trig;

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) begin
      sok_q <= 2'b00;
      mr_q  <= 2'b00;
    end else begin
      sok_q <= {sok_q[0], supply_ok};
      mr_q  <= {mr_q[0], man_rst_n};
    end
  end

  assign trig = !sok_q[1] || !mr_q[1];

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n)             hold_cnt <= HOLD_V;
    else if (trig)           hold_cnt <= HOLD_V;
    else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
  end

  assign rst_hi   = trig || (hold_cnt != '0);
  assign rst_lo_n = !rst_hi;

  logic [MW-1:0] pulse_len, quiet_len;
  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) begin
      pulse_len <= '0;
      quiet_len <= '0;
    end else begin
      if (!rst_hi) pulse_len <= '0;
      else if (pulse_len != '1) pulse_len <= pulse_len + 1'b1;
      if (trig) quiet_len <= '0;
      else if (quiet_len != '1) quiet_len <= quiet_len + 1'b1;
    end
  end

  a_r1_bad_supply_holds: assert property (@(posedge clk) disable iff (!init_n)
    !sok_q[1] |-> rst_hi);
  a_r7_drop_no_delay: assert property (@(posedge clk) disable iff (!init_n)
    $fell(sok_q[1]) |-> rst_hi);
  a_r5_manual_asserts: assert property (@(posedge clk) disable iff (!init_n)
    !mr_q[1] |-> rst_hi);
  a_r3_min_pulse: assert property (@(posedge clk) disable iff (!init_n)
    $fell(rst_hi) |-> (pulse_len >= MW'(MIN_CYC)));
  a_r2_hold_before_release: assert property (@(posedge clk) disable iff (!init_n)
    $fell(rst_hi) |-> (quiet_len >= MW'(HOLD_CYC)));
  a_r4_retrigger_reloads: assert property (@(posedge clk) disable iff (!init_n)
    trig |=> (hold_cnt == HOLD_V));
endmodule

// File: tb/supv_reset_gen_tb.sv
module supv_reset_gen_tb_top;
  localparam int HOLD = 12;
  localparam int MINC = 8;

  logic clk = 1'b0;
  logic init_n = 1'b0;
  logic supply_ok = 1'b0;
  logic man_rst_n = 1'b1;
  logic rst_hi, rst_lo_n;
  int total = 0;
  int bad = 0;

  always #10 clk = !clk;

  supv_reset_gen #(.HOLD_CYC(HOLD), .MIN_CYC(MINC)) dut_i (
    .clk(clk), .init_n(init_n), .supply_ok(supply_ok), .man_rst_n(man_rst_n),
    .rst_hi(rst_hi), .rst_lo_n(rst_lo_n));

  task automatic chk(string req, logic act, logic exp, int k);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s sample %0d: actual=%b expected=%b", req, k, act, exp);
    end
  endtask

  // Cycle j of mask low means the input is driven low during input cycle j.
  // Expected: asserted at sample k iff some low cycle j has j+2 <= k <= j+2+HOLD.
  task automatic run_pattern(string req, bit use_mr, logic [31:0] mask, int len, bit init_term);
    int last = 0;
    for (int j = 0; j < len; j++) if (mask[j]) last = j;
    if (init_term && last < 0) last = -1;
    if (use_mr) man_rst_n = !mask[0]; else supply_ok = !mask[0];
    for (int k = 1; k <= len + HOLD + 4; k++) begin
      logic e;
      @(negedge clk);
      e = 1'b0;
      if (init_term && k <= HOLD + 1) e = 1'b1;
      for (int j = 0; j < len; j++)
        if (mask[j] && k >= j + 2 && k <= j + 2 + HOLD) e = 1'b1;
      chk(req, rst_hi, e, k);
      chk("R6", rst_lo_n, !rst_hi, k);
      if (use_mr) man_rst_n = (k < len) ? !mask[k] : 1'b1;
      else        supply_ok = (k < len) ? !mask[k] : 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", rst_hi, 1'b1, 0);
    chk("R6", rst_lo_n, 1'b0, 0);
    // R1 + R8: power-up with supply low for 5 cycles after init release
    init_n = 1'b1;
    run_pattern("R1", 1'b0, 32'h1F, 5, 1'b1);
    // R2/R3/R7: supply glitches of every width 1..8
    for (int w = 1; w <= 8; w++)
      run_pattern("R2", 1'b0, (32'h1 << w) - 1, w, 1'b0);
    // R5: manual reset pulses of every width 1..8
    for (int w = 1; w <= 8; w++)
      run_pattern("R5", 1'b1, (32'h1 << w) - 1, w, 1'b0);
    // R4: brown-out during hold, 3 low, 6 good, 2 low
    run_pattern("R4", 1'b0, 32'b110_0000_0111, 11, 1'b0);
    // R3: single-cycle trigger still meets minimum length
    run_pattern("R3", 1'b0, 32'h1, 1, 1'b0);
    // R5: bouncing pushbutton
    run_pattern("R5", 1'b1, 32'b1010_0110_1011, 12, 1'b0);
    // R7: drop visible exactly two edges later
    supply_ok = 1'b0;
    @(negedge clk); chk("R7", rst_hi, 1'b0, 1);
    @(negedge clk); chk("R7", rst_hi, 1'b1, 2);
    supply_ok = 1'b1;
    repeat (HOLD + 4) @(negedge clk);
    chk("R2", rst_hi, 1'b0, 0);
    // R8: re-init mid-operation asserts, then releases after HOLD+2
    init_n = 1'b0;
    @(negedge clk); chk("R8", rst_hi, 1'b1, 0);
    init_n = 1'b1;
    run_pattern("R8", 1'b0, 32'h0, 0, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule